// File: doc/BRIEF.md
# Periodic Rate and Square-Wave Counter

This block is one channel of a periodic down-counter. A count value N is written through a one-cycle strobe. Each clock then steps the counter down. The `mode_i` pin selects between two waveforms:

- **Divide-by-N rate mode.** The output falls for a single clock once per N clocks.
- **Square-wave mode.** The output spends N/2 clocks high and N/2 low. For odd N it spends (N+1)/2 clocks high and (N-1)/2 low.

A gate input pauses and restarts the channel. A count written while the channel runs is held back until the current period or half-period ends. A gate restart can take it sooner.

The count write is a plain strobe with no back-pressure. A write is accepted in the cycle it is presented and cannot be refused. The one exception is a rejected value, which sets the error flag. A write of 0 stands for 2^CW clocks.

Top module: `rate_sqwave_ctr`

## Requirements
- R1: After reset `wave_o` is 1 and `bad_cnt_o` is 0, and the output stays high until a legal count has been written.
- R2: In rate mode (`mode_i`=0) with count N ≥ 2, `wave_o` is high for N-1 clocks and low for exactly one clock, so the period is N clocks.
- R3: A write of value 1 with `mode_i`=0 sets `bad_cnt_o` on the next clock and is otherwise ignored, so the running waveform is unchanged. Any legal write clears `bad_cnt_o` on the next clock.
- R4: In square-wave mode (`mode_i`=1) with even N, each half of the waveform lasts N/2 clocks.
- R5: In square-wave mode with odd N, the high half lasts (N+1)/2 clocks and the low half lasts (N-1)/2 clocks.
- R6: While `gate_i` is 0 the counter holds its value, and `wave_o` is 1 in the same cycle, even if it was low.
- R7: At the first clock edge where `gate_i` is seen high after being low, the counter reloads and `wave_o` is 1. The period or high half then restarts from full length.
- R8: A count written while the channel runs does not change the current period (rate mode) or half-period (square-wave mode). It takes effect at the next such boundary.
- R9: A gate restart that follows a count write loads the new count at once, without waiting for the boundary.
- R10: A count of 0 means 2^CW clocks. With CW=16 in square-wave mode, that gives 32768 clocks high and 32768 clocks low.
- R11: A first count write loads at the first clock edge after it where `gate_i` is high. The mode is captured with the write. In rate mode the first high stretch after the write is therefore N clocks when the gate is already high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Counting clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| gate_i | input | 1 | Count enable; a rising level restarts the channel |
| ld_stb_i | input | 1 | One-cycle count write strobe |
| ld_val_i | input | CW | Count value; 0 stands for 2^CW |
| mode_i | input | 1 | 0 = rate mode, 1 = square-wave mode, captured with each write |
| wave_o | output | 1 | Generated waveform |
| bad_cnt_o | output | 1 | Set by a rejected count write (value 1 in rate mode) |

## Verification
The bench runs rate mode with counts of 2, 5 and 10, and square-wave mode with even counts 6 and 8 and odd counts 3, 7 and 9. It measures each high and low run. The odd counts separate the one- and three-step first decrements from a plain step of two. The count of 2 exposes an off-by-one in where the rate pulse falls. Writes placed just after a period or half starts show whether a new count is deferred. The same writes followed by a gate restart show whether the restart takes the new count early. A zero count in square-wave mode tests the wrap to the full range.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
  typedef enum logic {
    MODE_RATE   = 1'b0,
    MODE_SQUARE = 1'b1
  } rsq_mode_e;
endpackage

// File: rtl/rsq_gate_edge.sv
module rsq_gate_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gate_i,
  output logic rise_o
);
  logic gate_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) gate_q <= 1'b0;
    else         gate_q <= gate_i;
  end

  // a restart is the first edge with the gate high after it was low
  assign rise_o = gate_i & ~gate_q;
endmodule

// File: rtl/rsq_count_hold.sv
module rsq_count_hold
  import rsq_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [CW-1:0] wval_i,
  input  rsq_mode_e     wmode_i,
  input  logic          take_i,
  output logic [CW-1:0] nxt_val_o,
  output rsq_mode_e     nxt_mode_o,
  output logic          pend_o,
  output logic          start_o,
  output logic          err_o
);
  localparam logic [CW-1:0] VAL_ONE = CW'(1);

  logic active_q;
  logic wr_bad, wr_ok;

  // a count of one cannot form a rate period: reject it
  assign wr_bad  = wr_i && (wmode_i == MODE_RATE) && (wval_i == VAL_ONE);
  assign wr_ok   = wr_i && !wr_bad;
  assign start_o = wr_ok && !active_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      nxt_val_o  <= '0;
      nxt_mode_o <= MODE_RATE;
      pend_o     <= 1'b0;
      active_q   <= 1'b0;
      err_o      <= 1'b0;
    end else begin
      // a write in the same cycle as a take becomes the next pending value
      if (wr_ok) begin
        nxt_val_o  <= wval_i;
        nxt_mode_o <= wmode_i;
        pend_o     <= 1'b1;
        active_q   <= 1'b1;
      end else if (take_i) begin
        pend_o <= 1'b0;
      end
      if (wr_bad)     err_o <= 1'b1;
      else if (wr_ok) err_o <= 1'b0;
    end
  end
endmodule

// File: rtl/rsq_step_engine.sv
module rsq_step_engine
  import rsq_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          gate_i,
  input  logic          rise_i,
  input  logic          start_i,
  input  logic          pend_i,
  input  logic [CW-1:0] nxt_val_i,
  input  rsq_mode_e     nxt_mode_i,
  output logic          take_o,
  output logic          wave_q_o,
  output logic [CW-1:0] cnt_o,
  output rsq_mode_e     mode_o
);
  localparam logic [CW-1:0] K1 = CW'(1);
  localparam logic [CW-1:0] K2 = CW'(2);
  localparam logic [CW-1:0] K3 = CW'(3);

  logic [CW-1:0] cnt_q, init_q, step, src_val;
  rsq_mode_e     mode_q, src_mode;
  logic          first_q, run_q, need_q;
  logic          load_evt, count_en, at_bound;

  assign load_evt = gate_i && (need_q || (run_q && rise_i));
  assign count_en = run_q && gate_i && !load_evt;

  // odd square counts: first step of the high half is 1, of the low half is 3
  always_comb begin
    if (mode_q == MODE_RATE)          step = K1;
    else if (first_q && init_q[0])    step = wave_q_o ? K1 : K3;
    else                              step = K2;
  end

  always_comb begin
    if (mode_q == MODE_RATE) at_bound = (cnt_q == K1);
    else                     at_bound = (cnt_q != '0) && (cnt_q <= step);
  end

  assign src_val  = pend_i ? nxt_val_i  : init_q;
  assign src_mode = pend_i ? nxt_mode_i : mode_q;
  assign take_o   = pend_i && (load_evt || (count_en && at_bound));
  assign cnt_o    = cnt_q;
  assign mode_o   = mode_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      init_q   <= '0;
      mode_q   <= MODE_RATE;
      wave_q_o <= 1'b1;
      first_q  <= 1'b0;
      run_q    <= 1'b0;
      need_q   <= 1'b0;
    end else begin
      if (start_i) need_q <= 1'b1;
      if (load_evt) begin
        cnt_q    <= src_val;
        init_q   <= src_val;
        mode_q   <= src_mode;
        wave_q_o <= 1'b1;
        first_q  <= 1'b1;
        run_q    <= 1'b1;
        need_q   <= 1'b0;
      end else if (!gate_i) begin
        wave_q_o <= 1'b1;
      end else if (count_en) begin
        if (at_bound) begin
          cnt_q   <= src_val;
          init_q  <= src_val;
          mode_q  <= src_mode;
          first_q <= 1'b1;
          if (src_mode != mode_q || mode_q == MODE_RATE) wave_q_o <= 1'b1;
          else                                           wave_q_o <= ~wave_q_o;
        end else begin
          cnt_q   <= cnt_q - step;
          first_q <= 1'b0;
          if (mode_q == MODE_RATE && cnt_q == K2) wave_q_o <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/rate_sqwave_ctr.sv
module rate_sqwave_ctr
  import rsq_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          gate_i,
  input  logic          ld_stb_i,
  input  logic [CW-1:0] ld_val_i,
  input  logic          mode_i,
  output logic          wave_o,
  output logic          bad_cnt_o
);
  logic          rise, take, pend, start, wave_q;
  logic [CW-1:0] nxt_val, cnt_cur;
  rsq_mode_e     nxt_mode, mode_act;

  rsq_gate_edge u_gate (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .gate_i(gate_i),
    .rise_o(rise)
  );

  rsq_count_hold #(.CW(CW)) u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (ld_stb_i),
    .wval_i    (ld_val_i),
    .wmode_i   (rsq_mode_e'(mode_i)),
    .take_i    (take),
    .nxt_val_o (nxt_val),
    .nxt_mode_o(nxt_mode),
    .pend_o    (pend),
    .start_o   (start),
    .err_o     (bad_cnt_o)
  );

  rsq_step_engine #(.CW(CW)) u_eng (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .gate_i    (gate_i),
    .rise_i    (rise),
    .start_i   (start),
    .pend_i    (pend),
    .nxt_val_i (nxt_val),
    .nxt_mode_i(nxt_mode),
    .take_o    (take),
    .wave_q_o  (wave_q),
    .cnt_o     (cnt_cur),
    .mode_o    (mode_act)
  );

  // a low gate forces the output high in the same cycle
  assign wave_o = wave_q | ~gate_i;
endmodule

// File: rtl/rsq_checker.sv
module rsq_checker
  import rsq_pkg::*;
#(
  parameter int CW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          gate_i,
  input logic          ld_stb_i,
  input logic [CW-1:0] ld_val_i,
  input logic          mode_i,
  input logic          wave_o,
  input logic          bad_cnt_o,
  input logic [CW-1:0] cnt_i,
  input rsq_mode_e     mode_act_i
);
  localparam logic [CW-1:0] V1 = CW'(1);

  assert_gate_low_high_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gate_i |-> wave_o);

  assert_gate_low_frozen_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gate_i |=> $stable(cnt_i));

  assert_rate_pulse_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_act_i == MODE_RATE && !wave_o && gate_i) |=> wave_o);

  assert_restart_high_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_i) |=> wave_o);

  assert_bad_write_flag_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_stb_i && !mode_i && ld_val_i == V1) |=> bad_cnt_o);

  assert_good_write_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_stb_i && !(!mode_i && ld_val_i == V1)) |=> !bad_cnt_o);

  assert_flag_cause_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bad_cnt_o) |-> ($past(ld_stb_i) && !$past(mode_i) && $past(ld_val_i) == V1));
endmodule

bind rate_sqwave_ctr rsq_checker #(.CW(CW)) u_rsq_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .gate_i    (gate_i),
  .ld_stb_i  (ld_stb_i),
  .ld_val_i  (ld_val_i),
  .mode_i    (mode_i),
  .wave_o    (wave_o),
  .bad_cnt_o (bad_cnt_o),
  .cnt_i     (cnt_cur),
  .mode_act_i(mode_act)
);

// File: tb/test_rate_sqwave_ctr.sv
module test_rate_sqwave_ctr;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          gate = 1'b1;
  logic          wr = 1'b0;
  logic [CW-1:0] val = '0;
  logic          mode = 1'b0;
  logic          out;
  logic          err;
  int            n_run = 0;
  int            n_fail = 0;

  always #2 clk = ~clk;

  rate_sqwave_ctr #(.CW(CW)) i_rate_sqwave_ctr (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .gate_i   (gate),
    .ld_stb_i (wr),
    .ld_val_i (val),
    .mode_i   (mode),
    .wave_o   (out),
    .bad_cnt_o(err)
  );

  task automatic chk(input string rq, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr = 1'b0; gate = 1'b1; mode = 1'b0; val = '0;
    repeat (3) step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic put(input logic m, input int v);
    mode = m; val = CW'(v); wr = 1'b1;
    step();
    wr = 1'b0;
  endtask

  task automatic wait_lvl(input logic v);
    int g = 0;
    while (out !== v && g < 200000) begin step(); g++; end
  endtask

  task automatic run_len(input logic v, output int n);
    n = 0;
    while (out === v && n < 200000) begin n++; step(); end
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 out after reset", int'(out), 1);
    chk("R1 err after reset", int'(err), 0);
    repeat (10) step();
    chk("R1 idle output", int'(out), 1);
  endtask

  task automatic t_rate(input int nv);
    int n;
    do_reset();
    put(1'b0, nv);
    run_len(1'b1, n); chk("R11 first high stretch", n, nv);
    run_len(1'b0, n); chk("R2 low pulse", n, 1);
    run_len(1'b1, n); chk("R2 high length", n, nv - 1);
    run_len(1'b0, n); chk("R2 second low pulse", n, 1);
  endtask

  task automatic t_gate_first();
    int n;
    do_reset();
    gate = 1'b0;
    put(1'b0, 4);
    repeat (5) step();
    chk("R11 waits for gate", int'(out), 1);
    gate = 1'b1;
    step();
    run_len(1'b1, n); chk("R11 load on gate high", n, 3);
  endtask

  task automatic t_bad();
    int n;
    do_reset();
    put(1'b0, 5);
    chk("R3 no flag on legal write", int'(err), 0);
    put(1'b0, 1);
    chk("R3 flag on count 1", int'(err), 1);
    wait_lvl(1'b0);
    run_len(1'b0, n);
    run_len(1'b1, n); chk("R3 waveform unchanged", n, 4);
    put(1'b0, 5);
    chk("R3 flag cleared", int'(err), 0);
  endtask

  task automatic t_square(input int nv, input string rq);
    int n;
    do_reset();
    put(1'b1, nv);
    wait_lvl(1'b0);
    run_len(1'b0, n); chk({rq, " low half"}, n, nv / 2);
    run_len(1'b1, n); chk({rq, " high half"}, n, (nv + 1) / 2);
    run_len(1'b0, n); chk({rq, " second low half"}, n, nv / 2);
  endtask

  task automatic t_gate_rate();
    int n, bad;
    do_reset();
    put(1'b0, 6);
    wait_lvl(1'b0);
    gate = 1'b0;
    #1;
    chk("R6 forced high in low pulse", int'(out), 1);
    bad = 0;
    for (int i = 0; i < 5; i++) begin step(); if (out !== 1'b1) bad++; end
    chk("R6 held high while gate low", bad, 0);
    gate = 1'b1;
    step();
    run_len(1'b1, n); chk("R7 rate restart high", n, 5);
    run_len(1'b0, n); chk("R7 rate restart pulse", n, 1);
  endtask

  task automatic t_gate_square();
    int n;
    do_reset();
    put(1'b1, 8);
    wait_lvl(1'b0);
    gate = 1'b0;
    #1;
    chk("R6 square forced high", int'(out), 1);
    step(); step();
    gate = 1'b1;
    step();
    run_len(1'b1, n); chk("R7 square restart high half", n, 4);
  endtask

  task automatic t_defer_rate();
    int n;
    do_reset();
    put(1'b0, 10);
    wait_lvl(1'b0);
    step();
    put(1'b0, 4);
    run_len(1'b1, n); chk("R8 old period kept", n + 1, 9);
    run_len(1'b0, n); chk("R8 pulse at boundary", n, 1);
    run_len(1'b1, n); chk("R8 new period used", n, 3);
  endtask

  task automatic t_defer_square();
    int n;
    do_reset();
    put(1'b1, 8);
    wait_lvl(1'b0);
    wait_lvl(1'b1);
    put(1'b1, 4);
    run_len(1'b1, n); chk("R8 square half kept", n + 1, 4);
    run_len(1'b0, n); chk("R8 square new half", n, 2);
  endtask

  task automatic t_trigger();
    int n;
    do_reset();
    put(1'b0, 10);
    wait_lvl(1'b0);
    step();
    put(1'b0, 4);
    gate = 1'b0;
    step();
    gate = 1'b1;
    step();
    run_len(1'b1, n); chk("R9 trigger loads new count", n, 3);
    run_len(1'b0, n); chk("R9 pulse after trigger", n, 1);
  endtask

  task automatic t_max();
    int n;
    do_reset();
    put(1'b1, 0);
    wait_lvl(1'b0);
    run_len(1'b0, n); chk("R10 full-range low half", n, 1 << (CW - 1));
    run_len(1'b1, n); chk("R10 full-range high half", n, 1 << (CW - 1));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R1..R11 actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_rate(5);
    t_rate(2);
    t_gate_first();
    t_bad();
    t_square(6, "R4 even 6");
    t_square(8, "R4 even 8");
    t_square(7, "R5 odd 7");
    t_square(3, "R5 odd 3");
    t_square(9, "R5 odd 9");
    t_gate_rate();
    t_gate_square();
    t_defer_rate();
    t_defer_square();
    t_trigger();
    t_max();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule